// File: doc/BRIEF.md
# Line Frame Multiplexer with CRC

This block turns a DS1 payload bit stream into a continuous line bit stream. The line stream is cut into fixed frames of 9,408 bits. At a line rate of 1.568 Mbps, one frame lasts 6 ms. Each frame carries four kinds of content:
- a 14-bit sync pattern;
- a 6-bit CRC that covers the frame before it;
- a 21-bit operations word;
- DS1 payload in every remaining position.

Payload bits arrive on their own strobe at about 1.544 Mbps, with a small frequency offset. They pass through a 16-entry elastic buffer. When the buffer runs low at a payload position, the block sends a stuff bit instead of a payload bit. A flag bit at the end of the frame reports whether any stuffing took place in that frame.

Line timing comes from `line_en_i`. Each high cycle moves the frame by one bit, and that bit appears on the outputs one clock later. A host writes the operations word into a holding register at any time. The block copies that register into the frame once per frame, at the first bit. A frame therefore never carries half of an old word and half of a new one.

Top module: `line_frame_mux`

## Requirements
- R1: Every frame is 9,408 line bits long. A line bit is produced for each cycle in which `line_en_i` is high, and it appears on `line_bit_o` with `line_vld_o` high one clock later. `sof_o` is high with frame bit 0 only.
- R2: Frame bits 0 to 13 carry the pattern 11111100000000, leftmost bit first.
- R3: Frame bits 14 to 19 carry a CRC, most significant bit first. It uses the generator x^6+x+1, starts from zero and is computed over bits 14 to 9,407 of the previous frame. The first frame after reset carries zero in this field.
- R4: Bit k of the operations word (k = 0 to 20) is sent at frame bit 20+448*k. The word comes from the host register as it stood just before frame bit 0. A host write in the same cycle as bit 0 shows up only in the following frame.
- R5: Every other frame bit, except bit 9,407, is a payload position. Payload bits leave the block in the order they arrived.
- R6: At a payload position, if the buffer holds fewer than 4 bits, a 0 is sent and no payload bit is consumed.
- R7: Frame bit 9,407 is 1 exactly when at least one stuff bit was sent earlier in the same frame.
- R8: The buffer holds at most 16 bits. A payload bit that arrives while 16 are held is discarded. Whether the buffer counts as full is judged before that cycle's read.
- R9: During and right after reset, `line_vld_o`, `sof_o` and `line_bit_o` are 0, the buffer is empty and the host word is zero.
- R10: In a cycle where `line_en_i` is low, no frame bit is produced, the frame position does not advance, and `line_vld_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_en_i | input | 1 | Line bit enable; one frame bit per high cycle |
| pay_bit_i | input | 1 | DS1 payload bit |
| pay_vld_i | input | 1 | Payload bit strobe |
| ops_wr_i | input | 1 | Host write strobe for the operations word |
| ops_data_i | input | 21 | Operations word written by the host |
| line_bit_o | output | 1 | Line bit |
| line_vld_o | output | 1 | Line bit valid |
| sof_o | output | 1 | Marks frame bit 0 |

## Verification
Two events can land on the same edge.

The first is a buffer read for a payload position together with a new payload write. It is provoked by holding the payload strobe high for a whole frame. The buffer then sits full while payload positions drain it, and the bench checks that the arriving bit is dropped on a full buffer even when a read happens in that cycle.

The second is a host write of the operations word together with the once-per-frame copy at bit 0. It is provoked by writing exactly on that cycle. The bench judges the result by decoding the operations field of two successive frames: the old word must appear first and the new word after it.

A reference model in the bench follows every line bit through all of this, so any misplaced payload bit also breaks the next frame's CRC.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  parameter int unsigned FRAME_BITS = 9408;
  parameter int unsigned SYNC_BITS  = 14;
  parameter int unsigned CRC_BITS   = 6;
  parameter int unsigned OPS_BITS   = 21;
  parameter int unsigned OPS_GAP    = 448;
  parameter int unsigned BUF_DEPTH  = 16;
  parameter int unsigned BUF_LOW    = 4;
  parameter logic [13:0] SYNC_PAT   = 14'b11111100000000;
  parameter logic [5:0]  CRC_GEN    = 6'b000011;

  typedef enum logic [2:0] {
    SL_SYNC, SL_CRC, SL_OPS, SL_PAY, SL_FLAG
  } slot_e;
endpackage

// File: rtl/lfm_slot_map.sv
module lfm_slot_map
  import lfm_pkg::*;
#(
  parameter int unsigned FRAME_LEN  = FRAME_BITS,
  parameter int unsigned SYNC_LEN   = SYNC_BITS,
  parameter int unsigned CRC_LEN    = CRC_BITS,
  parameter int unsigned OPS_LEN    = OPS_BITS,
  parameter int unsigned OPS_STRIDE = OPS_GAP,
  localparam int unsigned POS_W     = $clog2(FRAME_LEN),
  localparam int unsigned IDX_W     = $clog2((SYNC_LEN > OPS_LEN) ? SYNC_LEN : OPS_LEN)
) (
  input  logic [POS_W-1:0] pos_i,
  output slot_e            slot_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned OPS_BASE = SYNC_LEN + CRC_LEN;

  always_comb begin
    int unsigned p;
    int unsigned rel;
    p      = 32'(pos_i);
    rel    = (p >= OPS_BASE) ? p - OPS_BASE : 0;
    slot_o = SL_PAY;
    idx_o  = '0;
    if (p < SYNC_LEN) begin
      slot_o = SL_SYNC;
      idx_o  = IDX_W'(p);
    end else if (p < OPS_BASE) begin
      slot_o = SL_CRC;
      idx_o  = IDX_W'(p - SYNC_LEN);
    end else if (p == FRAME_LEN - 1) begin
      slot_o = SL_FLAG;
    end else if ((rel % OPS_STRIDE) == 0 && (rel / OPS_STRIDE) < OPS_LEN) begin
      slot_o = SL_OPS;
      idx_o  = IDX_W'(rel / OPS_STRIDE);
    end
  end
endmodule

// File: rtl/lfm_fifo.sv
module lfm_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LOW   = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic d_i,
  input  logic pop_i,
  output logic q_o,
  output logic low_o
);
  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full;   // full judged before this cycle's read
  assign low_o   = (cnt_q < CNT_W'(LOW));
  assign q_o     = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)   rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(pop_i);
    end
  end

  a_r8_full_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> (cnt_q == CNT_W'(DEPTH)));
  a_r6_read_has_margin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q >= CNT_W'(LOW)));
  a_r9_empty_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (cnt_q == '0));
endmodule

// File: rtl/lfm_crc.sv
module lfm_crc #(
  parameter int unsigned W    = 6,
  parameter logic [W-1:0] POLY = 6'b000011
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  input  logic         clr_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = bit_i ^ crc_q[W-1];
  assign nxt_o = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= clr_i ? '0 : nxt_o;
  end
endmodule

// File: rtl/line_frame_mux.sv
module line_frame_mux
  import lfm_pkg::*;
#(
  parameter int unsigned FRAME_LEN  = FRAME_BITS,
  parameter int unsigned SYNC_LEN   = SYNC_BITS,
  parameter int unsigned CRC_LEN    = CRC_BITS,
  parameter int unsigned OPS_LEN    = OPS_BITS,
  parameter int unsigned OPS_STRIDE = OPS_GAP,
  parameter int unsigned FIFO_DEPTH = BUF_DEPTH,
  parameter int unsigned LOW_MARK   = BUF_LOW,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = SYNC_PAT,
  parameter logic [CRC_LEN-1:0]  CRC_POLY  = CRC_GEN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_en_i,
  input  logic               pay_bit_i,
  input  logic               pay_vld_i,
  input  logic               ops_wr_i,
  input  logic [OPS_LEN-1:0] ops_data_i,
  output logic               line_bit_o,
  output logic               line_vld_o,
  output logic               sof_o
);
  localparam int unsigned POS_W = $clog2(FRAME_LEN);
  localparam int unsigned IDX_W = $clog2((SYNC_LEN > OPS_LEN) ? SYNC_LEN : OPS_LEN);

  logic [POS_W-1:0]   pos_q;
  slot_e              slot;
  logic [IDX_W-1:0]   idx;
  logic [OPS_LEN-1:0] ops_reg_q, ops_lat_q;
  logic [CRC_LEN-1:0] crc_hold_q, crc_nxt;
  logic               stuff_flag_q;
  logic               fifo_q, fifo_low, pop, stuff, last, tx_bit;
  logic               sync_bit, crc_bit, ops_bit;

  assign last  = (pos_q == POS_W'(FRAME_LEN - 1));
  assign pop   = line_en_i && (slot == SL_PAY) && !fifo_low;
  assign stuff = line_en_i && (slot == SL_PAY) && fifo_low;

  lfm_slot_map #(
    .FRAME_LEN(FRAME_LEN), .SYNC_LEN(SYNC_LEN), .CRC_LEN(CRC_LEN),
    .OPS_LEN(OPS_LEN), .OPS_STRIDE(OPS_STRIDE)
  ) u_map (
    .pos_i(pos_q), .slot_o(slot), .idx_o(idx)
  );

  lfm_fifo #(.DEPTH(FIFO_DEPTH), .LOW(LOW_MARK)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(pay_vld_i), .d_i(pay_bit_i),
    .pop_i(pop), .q_o(fifo_q), .low_o(fifo_low)
  );

  lfm_crc #(.W(CRC_LEN), .POLY(CRC_POLY)) u_crc (
    .clk_i, .rst_ni,
    .en_i(line_en_i && (slot != SL_SYNC)),
    .bit_i(tx_bit), .clr_i(last), .nxt_o(crc_nxt)
  );

  // field bit selects, MSB first for sync and CRC, LSB first for ops
  always_comb begin
    sync_bit = 1'b0;
    crc_bit  = 1'b0;
    ops_bit  = 1'b0;
    for (int k = 0; k < SYNC_LEN; k++)
      if (32'(idx) == k) sync_bit = SYNC_WORD[SYNC_LEN-1-k];
    for (int k = 0; k < CRC_LEN; k++)
      if (32'(idx) == k) crc_bit = crc_hold_q[CRC_LEN-1-k];
    for (int k = 0; k < OPS_LEN; k++)
      if (32'(idx) == k) ops_bit = ops_lat_q[k];
  end

  always_comb begin
    unique case (slot)
      SL_SYNC: tx_bit = sync_bit;
      SL_CRC:  tx_bit = crc_bit;
      SL_OPS:  tx_bit = ops_bit;
      SL_FLAG: tx_bit = stuff_flag_q;
      default: tx_bit = fifo_low ? 1'b0 : fifo_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q        <= '0;
      ops_reg_q    <= '0;
      ops_lat_q    <= '0;
      crc_hold_q   <= '0;
      stuff_flag_q <= 1'b0;
      line_bit_o   <= 1'b0;
      line_vld_o   <= 1'b0;
      sof_o        <= 1'b0;
    end else begin
      if (ops_wr_i) ops_reg_q <= ops_data_i;
      line_vld_o <= line_en_i;
      if (line_en_i) begin
        pos_q      <= last ? '0 : pos_q + 1'b1;
        line_bit_o <= tx_bit;
        sof_o      <= (pos_q == '0);
        if (pos_q == '0) begin
          ops_lat_q    <= ops_reg_q;   // old value wins over same-cycle write
          stuff_flag_q <= 1'b0;
        end else if (stuff) begin
          stuff_flag_q <= 1'b1;
        end
        if (last) crc_hold_q <= crc_nxt;
      end else begin
        sof_o <= 1'b0;
      end
    end
  end

  a_r1_vld_follows_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_en_i |=> line_vld_o);
  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_en_i |=> (!line_vld_o && $stable(pos_q)));
  a_r2_sof_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (line_vld_o && line_bit_o));
  a_r7_flag_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_en_i && pos_q == '0) |=> !stuff_flag_q);
  a_r6_stuff_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff |=> stuff_flag_q);
endmodule

// File: tb/line_frame_mux_tb.sv
module line_frame_mux_tb;
  localparam int FL = 9408;
  localparam logic [13:0] SYNCW = 14'b11111100000000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line_en, pay_bit, pay_vld, ops_wr;
  logic [20:0] ops_data;
  logic line_bit, line_vld, sof;

  always #2.5 clk = ~clk;

  line_frame_mux u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_en_i(line_en),
    .pay_bit_i(pay_bit), .pay_vld_i(pay_vld),
    .ops_wr_i(ops_wr), .ops_data_i(ops_data),
    .line_bit_o(line_bit), .line_vld_o(line_vld), .sof_o(sof)
  );

  int total = 0, bad = 0;
  // categories: 0 sync, 1 crc, 2 ops, 3 payload, 4 flag, 5 control
  int errs [6];
  int e_pos [6];
  int e_act [6];
  int e_exp [6];

  // reference model state
  int          m_pos;
  bit          m_q [$];
  logic [5:0]  m_crc, m_hold;
  logic [20:0] m_ops_reg, m_ops_lat;
  bit          m_flag;
  int          acc;
  int unsigned seed = 32'h1234_5678;
  int          wr_pos = -1;
  logic [20:0] wr_val;

  logic [20:0] cap_ops, done_ops;
  logic [5:0]  cap_crc, done_crc;
  bit          done_flag;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void dec(input int p, output int cat, output int idx);
    idx = 0;
    if (p < 14) begin cat = 0; idx = p; end
    else if (p < 20) begin cat = 1; idx = p - 14; end
    else if (p == FL - 1) cat = 4;
    else if ((p - 20) % 448 == 0 && (p - 20) / 448 < 21) begin cat = 2; idx = (p - 20) / 448; end
    else cat = 3;
  endfunction

  function automatic bit prng();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[0];
  endfunction

  task automatic model_reset();
    m_pos = 0; m_q.delete(); m_crc = '0; m_hold = '0;
    m_ops_reg = '0; m_ops_lat = '0; m_flag = 0; acc = 0;
    for (int i = 0; i < 6; i++) begin errs[i] = 0; e_pos[i] = 0; e_act[i] = 0; e_exp[i] = 0; end
  endtask

  task automatic note(input int c, input int p, input int a, input int e);
    if (errs[c] == 0) begin e_pos[c] = p; e_act[c] = a; e_exp[c] = e; end
    errs[c]++;
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit en, input bit pv, input bit pb, input bit wr, input logic [20:0] wd);
    int cat, idx, p;
    bit eb, stf, full_pre, fb;
    p = m_pos; cat = 5; idx = 0; eb = 0; stf = 0;
    line_en = en; pay_vld = pv; pay_bit = pb; ops_wr = wr; ops_data = wd;
    full_pre = (m_q.size() == 16);
    if (en) begin
      dec(p, cat, idx);
      case (cat)
        0: eb = SYNCW[13 - idx];
        1: eb = m_hold[5 - idx];
        2: eb = m_ops_lat[idx];
        4: eb = m_flag;
        default: if (m_q.size() < 4) begin eb = 0; stf = 1; end else eb = m_q.pop_front();
      endcase
      if (p == 0) begin m_ops_lat = m_ops_reg; m_flag = 0; end
      if (stf) m_flag = 1;
      if (cat != 0) begin
        fb = eb ^ m_crc[5];
        m_crc = {m_crc[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b0);
      end
      if (p == FL - 1) begin m_hold = m_crc; m_crc = '0; end
      m_pos = (p == FL - 1) ? 0 : p + 1;
    end
    if (pv && !full_pre) m_q.push_back(pb);
    if (wr) m_ops_reg = wd;
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      if (line_vld !== 1'b1 || sof !== (p == 0)) note(5, p, int'(sof), int'(p == 0));
      if (line_bit !== eb) note(cat, p, int'(line_bit), int'(eb));
      case (cat)
        1: cap_crc[5 - idx] = line_bit;
        2: cap_ops[idx] = line_bit;
        4: begin done_flag = line_bit; done_ops = cap_ops; done_crc = cap_crc; end
        default: ;
      endcase
    end else if (line_vld !== 1'b0 || sof !== 1'b0) begin
      note(5, p, int'(line_vld), 0);
    end
  endtask

  // mode: 0 steady rate, 1 no payload, 2 payload every cycle, 3 enable every other cycle
  task automatic run_frame(input int mode);
    bit en, pv, wr, fin;
    bit tog = 0;
    do begin
      tog = !tog;
      en = (mode == 3) ? tog : 1'b1;
      case (mode)
        1: pv = 0;
        2: pv = 1;
        default: begin
          acc += (mode == 3) ? 4632 : 9264;
          pv = (acc >= FL);
          if (pv) acc -= FL;
        end
      endcase
      wr = en && (wr_pos >= 0) && (m_pos == wr_pos);
      fin = en && (m_pos == FL - 1);
      step(en, pv, prng(), wr, wr ? wr_val : 21'h0);
      if (wr) wr_pos = -1;
    end while (!fin);
  endtask

  task automatic check_cats(input string tag);
    check(errs[0] == 0, "R2", {tag, " sync bits"}, e_act[0], e_exp[0]);
    check(errs[1] == 0, "R3", {tag, " crc bits"}, e_act[1], e_exp[1]);
    check(errs[2] == 0, "R4", {tag, " ops bits"}, e_act[2], e_exp[2]);
    check(errs[3] == 0, "R5 R6 R8", {tag, " payload bits"}, e_act[3], e_exp[3]);
    check(errs[4] == 0, "R7", {tag, " stuff flag"}, e_act[4], e_exp[4]);
    check(errs[5] == 0, "R1 R10", {tag, " valid/sof timing"}, e_act[5], e_exp[5]);
    if (errs[3] != 0) $display("  first payload mismatch at frame bit %0d", e_pos[3]);
    for (int i = 0; i < 6; i++) errs[i] = 0;
  endtask

  task automatic t_reset();
    line_en = 0; pay_vld = 0; pay_bit = 0; ops_wr = 0; ops_data = '0;
    rst_ni = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check(line_vld === 1'b0, "R9", "valid in reset", int'(line_vld), 0);
    check(sof === 1'b0, "R9", "sof in reset", int'(sof), 0);
    check(line_bit === 1'b0, "R9", "bit in reset", int'(line_bit), 0);
    rst_ni = 1;
    step(0, 0, 0, 0, '0);
    check(line_vld === 1'b0, "R10", "valid when idle", int'(line_vld), 0);
  endtask

  task automatic t_steady();
    step(0, 0, 0, 1, 21'h15A5A5);
    wr_pos = 4000; wr_val = 21'h0B3C7E;
    run_frame(0);
    check(done_crc == 6'd0, "R3", "first frame crc zero", done_crc, 0);
    check(done_ops == 21'h15A5A5, "R4", "mid-frame write does not tear", done_ops, 21'h15A5A5);
    run_frame(0);
    check(done_ops == 21'h0B3C7E, "R4", "write taken next frame", done_ops, 21'h0B3C7E);
    check_cats("steady");
  endtask

  task automatic t_collide();
    wr_pos = 0; wr_val = 21'h1F00F1;
    run_frame(0);
    check(done_ops == 21'h0B3C7E, "R4", "write at bit 0 deferred", done_ops, 21'h0B3C7E);
    run_frame(0);
    check(done_ops == 21'h1F00F1, "R4", "deferred write appears", done_ops, 21'h1F00F1);
    check_cats("collide");
  endtask

  task automatic t_starve();
    run_frame(1);
    check(done_flag == 1'b1, "R7", "flag set when starved", done_flag, 1);
    check_cats("starve");
  endtask

  task automatic t_flood();
    run_frame(2);
    check(done_flag == 1'b0, "R7", "flag clear when buffer full", done_flag, 0);
    check_cats("flood R8");
  endtask

  task automatic t_gaps();
    run_frame(3);
    check_cats("gaps R10");
  endtask

  initial begin
    t_reset();
    t_steady();
    t_collide();
    t_starve();
    t_flood();
    t_gaps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule